// File: doc/BRIEF.md
# Line Error Counter Bank

This block holds the performance-monitoring counters of a framed T1/E1 receive path. The framer sends single-cycle pulses for out-of-frame events, multiframes spent out of sync, CRC errors and framing-bit errors. It also sends a pulse at the end of each resynchronisation, with the frame alignment that was found. The bank counts these events. It raises per-counter event and overflow flags and combines the enabled flags into one interrupt line.

Software reaches the bank through a small byte-wide register port. Through this port it reads or presets the counters, reads the flags and sets the masks. It also selects one of three operating modes. RUN counts live. CLEAR holds every counter at zero. SAMPLE freezes the readable values between one-second ticks.

The mode is a three-state machine: MODE_RUN, MODE_SAMPLE and MODE_CLEAR. It changes only when the control register (address 9) is written. Writing a value with bit 0 set enters MODE_CLEAR from any state. Writing a value with bit 0 clear and bit 1 set enters MODE_SAMPLE. Writing a value with both bits clear enters MODE_RUN.

Top module: `lec_bank`

## Requirements
- R1: After reset, every readable address (0 to 9) returns 0, the mode is MODE_RUN and `irq` is low.
- R2: Each accepted pulse adds one to its counter. The layout is: address 0 holds the out-of-frame count in bits 3:0 and the alignment-change count in bits 7:4; address 1 holds the 8-bit out-of-sync multiframe count; address 2 holds the 8-bit framing-bit error count; the 16-bit CRC count has its low byte at address 3 and its high byte at address 4.
- R3: A counter that is at its maximum value wraps to zero on the next increment. The wrap sets that counter's bit in the overflow latch at address 6: bit 0 for out-of-frame, 1 for alignment change, 2 for multiframe, 3 for CRC and 4 for framing-bit.
- R4: The alignment-change count increments only on a `resync_pulse` whose `align_pos` differs from the value stored at the previous resync. After reset, the stored value is 0.
- R5: A write to a counter address presets the bytes it covers. An increment of the same counter in the same cycle is dropped, and the written value stands.
- R6: In MODE_CLEAR (control value 1), all counters and snapshots read 0. Pulses and counter writes have no effect, no event flag is set, and the control register reads 1. Writing 0 returns the bank to MODE_RUN, where counting resumes from 0.
- R7: In MODE_SAMPLE (control value 2, reads back 2), counter addresses return the snapshot. On each `sec_tick` the snapshot takes the live value, and the live counter restarts at 0, or at 1 if an increment arrives in that same cycle. Between ticks the reads do not change.
- R8: The event flags at address 5 are set by accepted events. Bit 1 is alignment change, 2 is multiframe, 3 is CRC, 4 is framing-bit and 5 is `sec_tick`. There is no out-of-frame event flag, so bit 0 always reads 0.
- R9: Overflow latch bits stay set until address 6 is read, and that read clears them. A bit that is set in the same cycle as the read remains set.
- R10: Reading address 5 clears the event flags. A flag that is set in the same cycle as the read remains set.
- R11: `irq` is high exactly when an event flag is set under its mask at address 7, or an overflow bit is set under its mask at address 8. A flag that is set without its mask never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oof_pulse | input | 1 | Out-of-frame event |
| mfoos_pulse | input | 1 | One multiframe elapsed while out of sync |
| crc_pulse | input | 1 | CRC error |
| fbe_pulse | input | 1 | Framing-bit error |
| resync_pulse | input | 1 | Resynchronisation complete |
| align_pos | input | ALIGN_W | Frame alignment found at resync |
| sec_tick | input | 1 | One-second tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears read-to-clear registers) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined masked interrupt |

## Verification
A counter that drops or doubles an increment shows up as a wrong byte on the very next read of its address. In MODE_SAMPLE, the error stays hidden until the following `sec_tick` moves the live value into the snapshot. A bad overflow or event flag appears on `irq` one cycle after the triggering pulse, if its mask is set; otherwise it appears on the next read of address 5 or 6. A second read of the same address then shows whether clear-on-read works. A stale alignment register only shows after two resyncs, as a wrong upper nibble at address 0.

// File: rtl/lec_pkg.sv
package lec_pkg;
    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_CLEAR  = 2'd1,
        MODE_SAMPLE = 2'd2
    } mode_e;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int CRC_W   = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_NIB   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MFO   = 4'd1;
    localparam logic [ADDR_W-1:0] A_FBE   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CRCL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CRCH  = 4'd4;
    localparam logic [ADDR_W-1:0] A_EVT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_OVF   = 4'd6;
    localparam logic [ADDR_W-1:0] A_EMSK  = 4'd7;
    localparam logic [ADDR_W-1:0] A_OMSK  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd9;

    // flag bit positions
    localparam int B_OOF  = 0;
    localparam int B_COFA = 1;
    localparam int B_MFO  = 2;
    localparam int B_CRC  = 3;
    localparam int B_FBE  = 4;
    localparam int B_SEC  = 5;
endpackage

// File: rtl/lec_counter.sv
module lec_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         tick,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] live,
    output logic [W-1:0] snap,
    output logic         ovf
);
    logic wr_any;
    assign wr_any = |wr_mask;
    assign ovf    = inc & ~clr & ~wr_any & ~tick & (&live);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            live <= '0;
            snap <= '0;
        end else begin
            if (tick) snap <= live;
            if (wr_any)    live <= (live & ~wr_mask) | (wdata & wr_mask);
            else if (tick) live <= W'(inc);
            else if (inc)  live <= live + 1'b1;
        end
    end

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live == '0 && snap == '0));
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_any) |=> ((live & $past(wr_mask)) == ($past(wdata) & $past(wr_mask))));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (live == '0));
    a_r7_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(snap));
endmodule

// File: rtl/lec_flags.sv
module lec_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (rd_clr ? '0 : q) | set;
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((q & $past(q)) == $past(q)));
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/lec_bank.sv
module lec_bank
    import lec_pkg::*;
#(
    parameter int ALIGN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 oof_pulse,
    input  logic                 mfoos_pulse,
    input  logic                 crc_pulse,
    input  logic                 fbe_pulse,
    input  logic                 resync_pulse,
    input  logic [ALIGN_W-1:0]   align_pos,
    input  logic                 sec_tick,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);
    localparam int NNIB = 2;
    localparam int NBYTE_CNT = 2;

    // ---------------- mode state machine ----------------
    mode_e mode_q, mode_d;
    logic  clr_all, sample_en;

    always_comb begin
        mode_d = mode_q;
        if (reg_wr && reg_addr == A_CTRL) begin
            if (reg_wdata[0])      mode_d = MODE_CLEAR;
            else if (reg_wdata[1]) mode_d = MODE_SAMPLE;
            else                   mode_d = MODE_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        clr_all   = 1'b0;
        sample_en = 1'b0;
        unique case (mode_q)
            MODE_RUN:    ;
            MODE_CLEAR:  clr_all   = 1'b1;
            MODE_SAMPLE: sample_en = 1'b1;
            default:     ;
        endcase
    end

    // ---------------- alignment tracking ----------------
    logic [ALIGN_W-1:0] align_q;
    logic               cofa_inc;
    assign cofa_inc = resync_pulse & (align_pos != align_q);

    always_ff @(posedge clk) begin
        if (!rst_n)            align_q <= '0;
        else if (resync_pulse) align_q <= align_pos;
    end

    logic tick;
    assign tick = sec_tick & sample_en;

    // ---------------- nibble counters: out-of-frame, alignment change ----------------
    logic [NIB_W-1:0] nib_live [NNIB];
    logic [NIB_W-1:0] nib_snap [NNIB];
    logic [NNIB-1:0]  nib_ovf;
    logic [NNIB-1:0]  nib_inc;
    assign nib_inc = {cofa_inc, oof_pulse};

    for (genvar gi = 0; gi < NNIB; gi++) begin : g_nib
        logic [NIB_W-1:0] msk;
        assign msk = (reg_wr && reg_addr == A_NIB) ? '1 : '0;
        lec_counter #(.W(NIB_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .inc(nib_inc[gi]), .tick(tick),
            .wr_mask(msk), .wdata(reg_wdata[gi*NIB_W +: NIB_W]),
            .live(nib_live[gi]), .snap(nib_snap[gi]), .ovf(nib_ovf[gi]));
    end

    // ---------------- byte counters: multiframe, framing-bit ----------------
    logic [DATA_W-1:0]    byt_live [NBYTE_CNT];
    logic [DATA_W-1:0]    byt_snap [NBYTE_CNT];
    logic [NBYTE_CNT-1:0] byt_ovf;
    logic [NBYTE_CNT-1:0] byt_inc;
    logic [ADDR_W-1:0]    byt_addr [NBYTE_CNT];
    assign byt_inc     = {fbe_pulse, mfoos_pulse};
    assign byt_addr[0] = A_MFO;
    assign byt_addr[1] = A_FBE;

    for (genvar gj = 0; gj < NBYTE_CNT; gj++) begin : g_byte
        logic [DATA_W-1:0] msk;
        assign msk = (reg_wr && reg_addr == byt_addr[gj]) ? '1 : '0;
        lec_counter #(.W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .inc(byt_inc[gj]), .tick(tick),
            .wr_mask(msk), .wdata(reg_wdata),
            .live(byt_live[gj]), .snap(byt_snap[gj]), .ovf(byt_ovf[gj]));
    end

    // ---------------- CRC counter ----------------
    logic [CRC_W-1:0] crc_live, crc_snap, crc_msk;
    logic             crc_ovf;
    assign crc_msk = {{DATA_W{reg_wr && reg_addr == A_CRCH}},
                      {DATA_W{reg_wr && reg_addr == A_CRCL}}};

    lec_counter #(.W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .inc(crc_pulse), .tick(tick),
        .wr_mask(crc_msk), .wdata({reg_wdata, reg_wdata}),
        .live(crc_live), .snap(crc_snap), .ovf(crc_ovf));

    // ---------------- flags ----------------
    logic [DATA_W-1:0] evt_set, ovf_set, evt_q, ovf_q, evt_mask, ovf_mask;

    always_comb begin
        evt_set         = '0;
        evt_set[B_COFA] = cofa_inc    & ~clr_all;
        evt_set[B_MFO]  = mfoos_pulse & ~clr_all;
        evt_set[B_CRC]  = crc_pulse   & ~clr_all;
        evt_set[B_FBE]  = fbe_pulse   & ~clr_all;
        evt_set[B_SEC]  = sec_tick    & ~clr_all;
        ovf_set         = '0;
        ovf_set[B_OOF]  = nib_ovf[0];
        ovf_set[B_COFA] = nib_ovf[1];
        ovf_set[B_MFO]  = byt_ovf[0];
        ovf_set[B_CRC]  = crc_ovf;
        ovf_set[B_FBE]  = byt_ovf[1];
    end

    lec_flags #(.W(DATA_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .set(evt_set),
        .rd_clr(reg_rd && reg_addr == A_EVT), .q(evt_q));
    lec_flags #(.W(DATA_W)) u_ovf (
        .clk(clk), .rst_n(rst_n), .set(ovf_set),
        .rd_clr(reg_rd && reg_addr == A_OVF), .q(ovf_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_mask <= '0;
            ovf_mask <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_EMSK) evt_mask <= reg_wdata;
            if (reg_addr == A_OMSK) ovf_mask <= reg_wdata;
        end
    end

    assign irq = (|(evt_q & evt_mask)) | (|(ovf_q & ovf_mask));

    // ---------------- readback ----------------
    logic [NIB_W-1:0]  v_oof, v_cofa;
    logic [DATA_W-1:0] v_mfo, v_fbe;
    logic [CRC_W-1:0]  v_crc;
    assign v_oof  = sample_en ? nib_snap[0] : nib_live[0];
    assign v_cofa = sample_en ? nib_snap[1] : nib_live[1];
    assign v_mfo  = sample_en ? byt_snap[0] : byt_live[0];
    assign v_fbe  = sample_en ? byt_snap[1] : byt_live[1];
    assign v_crc  = sample_en ? crc_snap    : crc_live;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_NIB:   reg_rdata = {v_cofa, v_oof};
            A_MFO:   reg_rdata = v_mfo;
            A_FBE:   reg_rdata = v_fbe;
            A_CRCL:  reg_rdata = v_crc[DATA_W-1:0];
            A_CRCH:  reg_rdata = v_crc[CRC_W-1:DATA_W];
            A_EVT:   reg_rdata = evt_q;
            A_OVF:   reg_rdata = ovf_q;
            A_EMSK:  reg_rdata = evt_mask;
            A_OMSK:  reg_rdata = ovf_mask;
            A_CTRL:  reg_rdata = {6'd0, mode_q};
            default: reg_rdata = '0;
        endcase
    end

    a_r8_no_oof_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q[B_OOF] == 1'b0);
    a_r4_cofa_needs_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_pulse && !clr_all && !(reg_wr && reg_addr == A_NIB) && !tick)
        |=> $stable(nib_live[1]));
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mask == '0 && ovf_mask == '0) |-> !irq);
    a_r6_clear_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !reg_rd) |=> $stable(evt_q));
endmodule

// File: tb/lec_bank_tb.sv
module lec_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oof_pulse = 0, mfoos_pulse = 0, crc_pulse = 0, fbe_pulse = 0;
    logic       resync_pulse = 0, sec_tick = 0;
    logic [7:0] align_pos = '0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lec_bank #(.ALIGN_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .oof_pulse(oof_pulse), .mfoos_pulse(mfoos_pulse),
        .crc_pulse(crc_pulse), .fbe_pulse(fbe_pulse), .resync_pulse(resync_pulse),
        .align_pos(align_pos), .sec_tick(sec_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // pulse set: bit0 oof, 1 mfoos, 2 crc, 3 fbe, 4 sec_tick
    task automatic pulse(input logic [4:0] which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {sec_tick, fbe_pulse, crc_pulse, mfoos_pulse, oof_pulse} = which;
            @(negedge clk);
            {sec_tick, fbe_pulse, crc_pulse, mfoos_pulse, oof_pulse} = '0;
        end
    endtask

    task automatic resync(input logic [7:0] pos);
        @(negedge clk);
        resync_pulse = 1; align_pos = pos;
        @(negedge clk);
        resync_pulse = 0;
    endtask

    task automatic wipe();
        logic [7:0] d;
        wr(4'd9, 8'h01);
        wr(4'd9, 8'h00);
        rd(4'd5, d);
        rd(4'd6, d);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 10; a++) rd_check("R1 reset read", 4'(a), 8'h00);
        check("R1 irq at reset", int'(irq), 0);
    endtask

    task automatic t_count();
        pulse(5'b00001, 3);
        pulse(5'b00010, 5);
        pulse(5'b01000, 2);
        pulse(5'b00100, 7);
        rd_check("R2 oof nibble", 4'd0, 8'h03);
        rd_check("R2 multiframe", 4'd1, 8'h05);
        rd_check("R2 framing", 4'd2, 8'h02);
        rd_check("R2 crc low", 4'd3, 8'h07);
        rd_check("R2 crc high", 4'd4, 8'h00);
    endtask

    task automatic t_cofa();
        resync(8'd0);
        rd_check("R4 same alignment no count", 4'd0, 8'h03);
        resync(8'd5);
        resync(8'd5);
        resync(8'd9);
        rd_check("R4 two moves counted", 4'd0, 8'h23);
        wipe();
    endtask

    task automatic t_wrap();
        wr(4'd2, 8'hFE);
        pulse(5'b01000, 2);
        rd_check("R3 framing wrap", 4'd2, 8'h00);
        rd_check("R3 R9 ovf bit4", 4'd6, 8'h10);
        rd_check("R9 cleared by read", 4'd6, 8'h00);
        wr(4'd3, 8'hFF); wr(4'd4, 8'hFF);
        pulse(5'b00100, 1);
        rd_check("R3 crc wrap low", 4'd3, 8'h00);
        rd_check("R3 crc wrap high", 4'd4, 8'h00);
        wr(4'd0, 8'h0F);
        pulse(5'b00001, 1);
        rd_check("R3 oof wrap", 4'd0, 8'h00);
        rd_check("R3 ovf bits crc+oof", 4'd6, 8'h09);
        wipe();
    endtask

    task automatic t_race();
        wr(4'd2, 8'hFF);
        @(negedge clk);
        reg_rd = 1; reg_addr = 4'd6; fbe_pulse = 1;
        @(negedge clk);
        reg_rd = 0; fbe_pulse = 0;
        rd_check("R9 set wins over read clear", 4'd6, 8'h10);
        @(negedge clk);
        reg_wr = 1; reg_addr = 4'd1; reg_wdata = 8'h40; mfoos_pulse = 1;
        @(negedge clk);
        reg_wr = 0; mfoos_pulse = 0;
        rd_check("R5 write wins over increment", 4'd1, 8'h40);
        wipe();
    endtask

    task automatic t_clear();
        wr(4'd2, 8'h11);
        wr(4'd9, 8'h01);
        rd_check("R6 ctrl reads clear", 4'd9, 8'h01);
        rd_check("R6 held zero", 4'd2, 8'h00);
        pulse(5'b01110, 2);
        wr(4'd1, 8'h33);
        rd_check("R6 write ignored", 4'd1, 8'h00);
        rd_check("R6 pulses ignored", 4'd2, 8'h00);
        rd_check("R6 no event flags", 4'd5, 8'h00);
        wr(4'd9, 8'h00);
        pulse(5'b01000, 1);
        rd_check("R6 resumes from zero", 4'd2, 8'h01);
        wipe();
    endtask

    task automatic t_sample();
        wr(4'd9, 8'h02);
        rd_check("R7 ctrl reads sample", 4'd9, 8'h02);
        pulse(5'b01000, 3);
        rd_check("R7 snapshot before tick", 4'd2, 8'h00);
        pulse(5'b11000, 1);
        rd_check("R7 snapshot after tick", 4'd2, 8'h03);
        pulse(5'b01000, 6);
        rd_check("R7 stable between ticks", 4'd2, 8'h03);
        pulse(5'b10000, 1);
        rd_check("R7 live restarted with same-cycle inc", 4'd2, 8'h07);
        rd_check("R8 R10 sec and framing flags", 4'd5, 8'h30);
        rd_check("R10 flags cleared by read", 4'd5, 8'h00);
        wr(4'd9, 8'h00);
        wipe();
    endtask

    task automatic t_irq();
        wr(4'd7, 8'h10);
        pulse(5'b00100, 1);
        check("R11 unmasked crc event keeps irq low", int'(irq), 0);
        pulse(5'b01000, 1);
        check("R11 framing event raises irq", int'(irq), 1);
        rd_check("R8 event bits crc+framing", 4'd5, 8'h18);
        check("R11 irq drops after read", int'(irq), 0);
        wr(4'd8, 8'h04);
        wr(4'd1, 8'hFF);
        pulse(5'b00010, 1);
        check("R11 overflow raises irq", int'(irq), 1);
        rd_check("R3 multiframe ovf bit2", 4'd6, 8'h04);
        check("R11 irq drops after ovf read", int'(irq), 0);
        rd_check("R8 multiframe event bit", 4'd5, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_count();
        t_cofa();
        t_wrap();
        t_race();
        t_clear();
        t_sample();
        t_irq();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule